// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This sequential unit owns the two 32-bit special result registers HI and LO of a 32-bit integer core. A caller issues one operation at a time. It raises `start_i` for one cycle and drives a 6-bit function code and two operand words (`rs_i`, `rt_i`) with it.

Multiplication puts a 64-bit product into HI:LO. Division puts the remainder into HI and the quotient into LO. Both use bit-serial datapaths, so they take many cycles, and `busy_o` stays high for that whole time. Transfer operations copy an operand into HI or LO. Read operations return HI or LO on `rdata_o` one cycle after they are accepted.

A start is accepted only while `busy_o` is low. The core must therefore stall a read of HI or LO until `busy_o` falls.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, HI and LO are zero and `busy_o` and `rdata_valid_o` are low.
- R2: An accepted code 0x11 loads HI from `rs_i` and leaves LO unchanged. An accepted code 0x13 loads LO from `rs_i` and leaves HI unchanged.
- R3: An accepted code 0x10 (read HI) or 0x12 (read LO) sets `rdata_valid_o` high in the next cycle. In that cycle `rdata_o` holds the register value. `rdata_valid_o` is never high unless a start was accepted in the previous cycle.
- R4: Code 0x18 multiplies the operands as two's-complement numbers. The upper 32 bits of the 64-bit product go to HI and the lower 32 bits go to LO.
- R5: Code 0x19 multiplies the operands as unsigned numbers, with the same HI/LO placement as R4.
- R6: Code 0x1A divides signed `rs_i` by signed `rt_i`. LO receives the quotient, truncated toward zero. HI receives the remainder, which has the sign of the dividend. For 0x80000000 / -1, LO is 0x80000000 and HI is 0.
- R7: Code 0x1B divides unsigned `rs_i` by unsigned `rt_i`. The quotient goes to LO and the remainder goes to HI.
- R8: A division (0x1A or 0x1B) with `rt_i` equal to zero leaves HI and LO unchanged and does not raise `busy_o`.
- R9: An accepted multiply, or a division with a nonzero divisor, raises `busy_o` in the next cycle. `busy_o` stays high for at most 33 cycles and falls in the cycle after the result is written.
- R10: While `busy_o` is high, a start of any code is ignored: HI and LO are not written and no read data is returned. HI and LO keep their values until the running operation completes.
- R11: An accepted start with any function code not listed above changes neither HI nor LO, does not raise `busy_o` and returns no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue pulse for one operation |
| func_i | input | 6 | Function code |
| rs_i | input | 32 | First operand, dividend or multiplicand, and source for transfers |
| rt_i | input | 32 | Second operand, divisor or multiplier |
| busy_o | output | 1 | A multiply or divide is in progress |
| rdata_o | output | 32 | Value of HI or LO returned by a read |
| rdata_valid_o | output | 1 | `rdata_o` is valid in this cycle |

## Verification
The assertions check the following on every cycle:
- Transfers into HI and LO each touch only their own register.
- A division by zero leaves both registers as they were and never raises busy.
- Busy rises after every long operation and stays within its cycle bound.
- HI and LO stay frozen while busy.
- Read data appears only after a start issued while idle.

The arithmetic itself can only be shown by the bench's scenarios. These compare HI and LO after each operation against values computed independently. They cover:
- mixed-sign products;
- truncation and remainder sign in signed division;
- the most-negative-over-minus-one case;
- unsigned operands with the top bit set;
- starts issued mid-operation being dropped.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  localparam int FUNC_W = 6;

  typedef enum logic [FUNC_W-1:0] {
    F_MFHI  = 6'h10,
    F_MTHI  = 6'h11,
    F_MFLO  = 6'h12,
    F_MTLO  = 6'h13,
    F_MULT  = 6'h18,
    F_MULTU = 6'h19,
    F_DIV   = 6'h1A,
    F_DIVU  = 6'h1B
  } func_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV
  } state_e;
endpackage

// File: rtl/hilo_mul_seq.sv
// Unsigned shift-add multiplier, one multiplier bit per cycle.
module hilo_mul_seq #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int CW = $clog2(W);

  logic          run_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  a_q, hi_q, lo_q;
  logic [W:0]    sum;

  assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, a_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        a_q   <= a_i;
        hi_q  <= '0;
        lo_q  <= b_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        hi_q  <= sum[W:1];
        lo_q  <= {sum[0], lo_q[W-1:1]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = {hi_q, lo_q};
endmodule

// File: rtl/hilo_div_seq.sv
// Unsigned restoring divider, one quotient bit per cycle.
module hilo_div_seq #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W);

  logic          run_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  d_q, rem_q, quo_q;
  logic [W:0]    shifted, diff;
  logic          fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, d_q};
  assign fits    = shifted >= {1'b0, d_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      d_q    <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        d_q   <= divisor_i;
        rem_q <= '0;
        quo_q <= dividend_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [W-1:0]      rs_i,
  input  logic [W-1:0]      rt_i,
  output logic              busy_o,
  output logic [W-1:0]      rdata_o,
  output logic              rdata_valid_o
);
  state_e       state_q;
  logic [W-1:0] hi_q, lo_q, rdata_q;
  logic         rvalid_q, neg_a_q, neg_b_q;

  logic           accept, is_mul, is_div, signed_op, neg_a, neg_b;
  logic           mul_start, div_start, mul_done, div_done;
  logic [W-1:0]   a_mag, b_mag, quo, rem, quo_fix, rem_fix;
  logic [2*W-1:0] prod, prod_fix;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign is_mul    = (func_i == F_MULT) || (func_i == F_MULTU);
  assign is_div    = (func_i == F_DIV) || (func_i == F_DIVU);
  assign signed_op = (func_i == F_MULT) || (func_i == F_DIV);
  assign neg_a     = signed_op && rs_i[W-1];
  assign neg_b     = signed_op && rt_i[W-1];
  assign a_mag     = neg_a ? -rs_i : rs_i;
  assign b_mag     = neg_b ? -rt_i : rt_i;
  assign mul_start = accept && is_mul;
  assign div_start = accept && is_div && (rt_i != '0);

  hilo_mul_seq #(.W(W)) i_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (mul_start),
    .a_i     (a_mag),
    .b_i     (b_mag),
    .done_o  (mul_done),
    .prod_o  (prod)
  );

  hilo_div_seq #(.W(W)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (a_mag),
    .divisor_i  (b_mag),
    .done_o     (div_done),
    .quo_o      (quo),
    .rem_o      (rem)
  );

  // Sign restore: quotient negative on differing signs, remainder follows dividend.
  assign prod_fix = (neg_a_q ^ neg_b_q) ? -prod : prod;
  assign quo_fix  = (neg_a_q ^ neg_b_q) ? -quo : quo;
  assign rem_fix  = neg_a_q ? -rem : rem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      hi_q     <= '0;
      lo_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      neg_a_q  <= 1'b0;
      neg_b_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      if (accept) begin
        case (func_i)
          F_MFHI: begin rdata_q <= hi_q; rvalid_q <= 1'b1; end
          F_MFLO: begin rdata_q <= lo_q; rvalid_q <= 1'b1; end
          F_MTHI: hi_q <= rs_i;
          F_MTLO: lo_q <= rs_i;
          default: ;
        endcase
        if (mul_start || div_start) begin
          neg_a_q <= neg_a;
          neg_b_q <= neg_b;
        end
        if (mul_start) state_q <= ST_MUL;
        else if (div_start) state_q <= ST_DIV;
      end else if (state_q == ST_MUL && mul_done) begin
        hi_q    <= prod_fix[2*W-1:W];
        lo_q    <= prod_fix[W-1:0];
        state_q <= ST_IDLE;
      end else if (state_q == ST_DIV && div_done) begin
        hi_q    <= rem_fix;
        lo_q    <= quo_fix;
        state_q <= ST_IDLE;
      end
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
endmodule

// File: rtl/hilo_muldiv_checker.sv
module hilo_muldiv_checker
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [W-1:0]      rs_i,
  input logic [W-1:0]      rt_i,
  input logic              busy_o,
  input logic              rdata_valid_o,
  input logic [W-1:0]      hi_q,
  input logic [W-1:0]      lo_q
);
  localparam int BUSY_MAX = W + 1;

  logic idle_start, div_op;
  int   busy_cnt;

  assign idle_start = start_i && !busy_o;
  assign div_op     = (func_i == F_DIV) || (func_i == F_DIVU);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= 0;
    else         busy_cnt <= busy_o ? busy_cnt + 1 : 0;
  end

  AST_MTHI_ONLY_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && func_i == F_MTHI |=> hi_q == $past(rs_i) && $stable(lo_q)); // R2
  AST_MTLO_ONLY_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && func_i == F_MTLO |=> lo_q == $past(rs_i) && $stable(hi_q)); // R2
  AST_RDATA_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $past(idle_start)); // R3
  AST_DIV_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && div_op && rt_i == '0 |=> $stable(hi_q) && $stable(lo_q) && !busy_o); // R8
  AST_BUSY_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && (func_i == F_MULT || func_i == F_MULTU || (div_op && rt_i != '0))
    |=> busy_o); // R9
  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= BUSY_MAX); // R9
  AST_HILO_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o || ($stable(hi_q) && $stable(lo_q))); // R10
  AST_NO_RDATA_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o |=> !rdata_valid_o); // R10
endmodule

bind hilo_muldiv_unit hilo_muldiv_checker #(.W(W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .func_i        (func_i),
  .rs_i          (rs_i),
  .rt_i          (rt_i),
  .busy_o        (busy_o),
  .rdata_valid_o (rdata_valid_o),
  .hi_q          (hi_q),
  .lo_q          (lo_q)
);

// File: tb/test_hilo_muldiv_unit.sv
`timescale 1ns/1ps
module test_hilo_muldiv_unit;
  localparam logic [5:0] MFHI = 6'h10, MTHI = 6'h11, MFLO = 6'h12, MTLO = 6'h13;
  localparam logic [5:0] MULT = 6'h18, MULTU = 6'h19, DIV = 6'h1A, DIVU = 6'h1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  func = '0;
  logic [31:0] rs = '0, rt = '0;
  logic        busy, rvalid;
  logic [31:0] rdata;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  hilo_muldiv_unit i_hilo_muldiv_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .func_i(func),
    .rs_i(rs), .rt_i(rt), .busy_o(busy), .rdata_o(rdata), .rdata_valid_o(rvalid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one start pulse; returns at the negedge after the accepting edge.
  task automatic issue(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    start = 1'b1; func = f; rs = a; rt = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic read_reg(logic [5:0] f, string req, logic [31:0] exp);
    issue(f, 32'h0, 32'h0);
    check({req, " rvalid"}, 32'(rvalid), 32'd1);
    check({req, " rdata"}, rdata, exp);
  endtask

  task automatic wait_idle(string req);
    int cyc = 0;
    while (busy && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check({req, " busy bounded"}, 32'(cyc <= 33 && !busy), 32'd1);
  endtask

  function automatic logic [63:0] model(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r;
    logic [63:0] ua = {32'd0, a}, ub = {32'd0, b};
    logic [63:0] u;
    case (f)
      MULT:  begin r = sa * sb; return r; end
      MULTU: begin u = ua * ub; return u; end
      DIV:   begin r = sa / sb; u = r; r = sa % sb; return {r[31:0], u[31:0]}; end
      default: begin u = ua / ub; r = ua % ub; return {r[31:0], u[31:0]}; end
    endcase
  endfunction

  task automatic run_op(logic [5:0] f, logic [31:0] a, logic [31:0] b, string req);
    logic [63:0] exp = model(f, a, b);
    issue(f, a, b);
    check({req, " busy raised"}, 32'(busy), 32'd1); // R9
    wait_idle(req);
    read_reg(MFHI, {req, " HI"}, exp[63:32]);
    read_reg(MFLO, {req, " LO"}, exp[31:0]);
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 rvalid", 32'(rvalid), 32'd0);
    read_reg(MFHI, "R1 HI", 32'h0);
    read_reg(MFLO, "R1 LO", 32'h0);
  endtask

  task automatic t_moves();
    issue(MTHI, 32'hA5A5_0001, 32'hFFFF_FFFF);
    issue(MTLO, 32'h1234_5678, 32'h0);
    read_reg(MFHI, "R2 HI after both", 32'hA5A5_0001);
    read_reg(MFLO, "R2 LO after both", 32'h1234_5678);
    issue(MTHI, 32'h0BAD_F00D, 32'h0);
    read_reg(MFLO, "R2 LO kept", 32'h1234_5678);
    read_reg(MFHI, "R3 HI read", 32'h0BAD_F00D);
  endtask

  task automatic t_mult();
    run_op(MULT, 32'd7, 32'd6, "R4 pos*pos");
    run_op(MULT, 32'hFFFF_FFFD, 32'd1000, "R4 neg*pos");
    run_op(MULT, 32'h8000_0000, 32'h8000_0000, "R4 min*min");
    run_op(MULT, 32'h8000_0000, 32'h7FFF_FFFF, "R4 min*max");
    run_op(MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 max*max");
    run_op(MULTU, 32'h8000_0001, 32'd3, "R5 msb set");
    run_op(MULTU, 32'h0, 32'hDEAD_BEEF, "R5 zero");
  endtask

  task automatic t_div();
    run_op(DIV, 32'd7, 32'd2, "R6 7/2");
    run_op(DIV, 32'hFFFF_FFF9, 32'd2, "R6 -7/2");
    run_op(DIV, 32'd7, 32'hFFFF_FFFE, "R6 7/-2");
    run_op(DIV, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6 -7/-2");
    run_op(DIV, 32'h8000_0000, 32'hFFFF_FFFF, "R6 min/-1");
    run_op(DIVU, 32'hFFFF_FFF9, 32'd2, "R7 big/2");
    run_op(DIVU, 32'd5, 32'hFFFF_FFFF, "R7 small/big");
    run_op(DIVU, 32'h8000_0000, 32'h8000_0000, "R7 equal");
  endtask

  task automatic t_divzero();
    issue(MTHI, 32'h1111_2222, 32'h0);
    issue(MTLO, 32'h3333_4444, 32'h0);
    issue(DIV, 32'd99, 32'h0);
    check("R8 DIV no busy", 32'(busy), 32'd0);
    issue(DIVU, 32'hFFFF_0000, 32'h0);
    check("R8 DIVU no busy", 32'(busy), 32'd0);
    read_reg(MFHI, "R8 HI kept", 32'h1111_2222);
    read_reg(MFLO, "R8 LO kept", 32'h3333_4444);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] exp = model(MULT, 32'hFFFF_FF00, 32'h0001_0003);
    issue(MULT, 32'hFFFF_FF00, 32'h0001_0003);
    issue(MTHI, 32'hCAFE_CAFE, 32'h0);
    issue(MFHI, 32'h0, 32'h0);
    check("R10 no rvalid while busy", 32'(rvalid), 32'd0);
    issue(MTLO, 32'hBEEF_BEEF, 32'h0);
    issue(DIV, 32'd10, 32'd3);
    wait_idle("R10");
    read_reg(MFHI, "R10 HI from mult", exp[63:32]);
    read_reg(MFLO, "R10 LO from mult", exp[31:0]);
  endtask

  task automatic t_unknown();
    issue(MTHI, 32'h5555_AAAA, 32'h0);
    issue(MTLO, 32'hAAAA_5555, 32'h0);
    issue(6'h1C, 32'hFFFF_FFFF, 32'h2);
    check("R11 no busy", 32'(busy), 32'd0);
    check("R11 no rvalid", 32'(rvalid), 32'd0);
    issue(6'h00, 32'h1, 32'h1);
    read_reg(MFHI, "R11 HI kept", 32'h5555_AAAA);
    read_reg(MFLO, "R11 LO kept", 32'hAAAA_5555);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_moves();
    t_mult();
    t_div();
    t_divzero();
    t_busy_ignore();
    t_unknown();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end
endmodule